// File: doc/BRIEF.md
# Encoded Interrupt Level Decoder

This block turns a 4-bit encoded interrupt request level into per-source command strobes for a chain of level-specific interrupt sources. A level of 0 means that no request is present; levels 1 to 15 rise in priority. Each nonzero level selects exactly one chain position. That source is told to assert, and to enable if it has no enable yet. Every other source in the chain that is currently asserted is told to deassert. The strobes feed the assert, deassert and enable-step inputs of a downstream pending aggregator, and the aggregator reports back each source's asserted state and whether its enable counter is zero.

The level is captured in a register. Commands are issued only in the one cycle after a new level value has been captured. All chain positions receive their commands in that same cycle as parallel bit vectors, where bit i addresses chain position i. Chain position p is selected by level 15 - p, which is the level XOR 15. Level 15 therefore selects position 0. Level 0 maps to position 15, which lies outside a 15-entry chain, so no source is selected.

Top module: `irl_level_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, all three strobe vectors are zero. The captured level resets to 0.
- R2: When the level sampled at a clock edge equals the previously captured level, all strobe vectors are zero in the following cycle.
- R3: A new nonzero level L selects chain position 15 - L (L XOR 15). Bit i of every strobe vector addresses position i, so level 15 drives bit 0 and level 1 drives bit 14.
- R4: The selected position gets an assert strobe only if its asserted status input is 0. No other position ever gets an assert strobe.
- R5: The selected position gets an enable strobe only if its enable-counter-zero input is 1. No other position ever gets an enable strobe.
- R6: Every non-selected position whose asserted status is 1 gets a deassert strobe. The selected position never gets one.
- R7: A new level of 0 selects no position. No assert or enable strobes are issued, and every currently asserted source gets a deassert strobe.
- R8: Strobes appear in the cycle right after the clock edge that captured the new level. They last one cycle while the level stays unchanged.
- R9: The assert vector and the enable vector each have at most one bit set. No position has assert and deassert set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| level_i | input | 4 | Encoded request level, 0 = none, 15 = highest |
| src_active_i | input | 15 | Asserted state of each chain source, bit i = position i |
| src_cnt_zero_i | input | 15 | Enable counter of each chain source is zero |
| assert_stb_o | output | 15 | Assert step for a chain source |
| deassert_stb_o | output | 15 | Deassert step for a chain source |
| enable_stb_o | output | 15 | Enable step for a chain source |

## Verification
Some properties are checked by assertions on every cycle. These are: the one-hot limits on the assert and enable vectors, that no position is told to assert and deassert at once, and that assert and enable strobes only go to positions whose status allows them. The assertions also check that a held level produces silence and that level 0 produces no assert or enable. The level-to-position mapping, the exact set of deassert targets, the single-cycle pulse width and behaviour across a reset in mid-run can only be shown by the bench scenarios. In those scenarios a reference model predicts the full strobe vectors for chosen status patterns.

// File: rtl/irl_pkg.sv
package irl_pkg;

  localparam int unsigned IRL_LVL_W_DEF   = 4;
  localparam int unsigned IRL_CHAIN_N_DEF = 15;

  // Command bundle produced for one chain position in an update cycle.
  typedef struct packed {
    logic asrt;
    logic deasrt;
    logic enab;
  } irl_cmd_t;

endpackage

// File: rtl/irl_level_reg.sv
module irl_level_reg #(
  parameter int unsigned LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level_i,
  output logic [LVL_W-1:0] level_q,
  output logic             update_q
);

  logic             lvl_load;
  logic [LVL_W-1:0] level_d;
  logic             update_d;

  // next-state
  always_comb begin
    lvl_load = (level_i != level_q);
    level_d  = level_q;
    if (lvl_load) begin
      level_d = level_i;
    end
    update_d = lvl_load;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q  <= '0;
      update_q <= 1'b0;
    end else begin
      if (lvl_load) begin
        level_q <= level_d;
      end
      update_q <= update_d;
    end
  end

endmodule

// File: rtl/irl_pos_decode.sv
module irl_pos_decode #(
  parameter int unsigned LVL_W   = 4,
  parameter int unsigned CHAIN_N = 15
) (
  input  logic [LVL_W-1:0]   level_q,
  input  logic               update_q,
  output logic [CHAIN_N-1:0] sel_oh
);

  localparam int unsigned LVL_MAX = (1 << LVL_W) - 1;

  // Position i answers to level LVL_MAX - i (level XOR all-ones).
  for (genvar gi = 0; gi < CHAIN_N; gi++) begin : g_pos
    localparam logic [LVL_W-1:0] MATCH = LVL_W'(LVL_MAX - gi);
    always_comb begin
      sel_oh[gi] = update_q && (level_q == MATCH);
    end
  end

endmodule

// File: rtl/irl_strobe_cell.sv
module irl_strobe_cell
  import irl_pkg::*;
(
  input  logic     update_q,
  input  logic     sel,
  input  logic     active,
  input  logic     cnt_zero,
  output irl_cmd_t cmd
);

  always_comb begin
    cmd        = '0;
    if (update_q) begin
      if (sel) begin
        cmd.asrt = !active;
        cmd.enab = cnt_zero;
      end else begin
        cmd.deasrt = active;
      end
    end
  end

endmodule

// File: rtl/irl_level_decoder.sv
module irl_level_decoder
  import irl_pkg::*;
#(
  parameter int unsigned LVL_W   = IRL_LVL_W_DEF,
  parameter int unsigned CHAIN_N = IRL_CHAIN_N_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LVL_W-1:0]   level_i,
  input  logic [CHAIN_N-1:0] src_active_i,
  input  logic [CHAIN_N-1:0] src_cnt_zero_i,
  output logic [CHAIN_N-1:0] assert_stb_o,
  output logic [CHAIN_N-1:0] deassert_stb_o,
  output logic [CHAIN_N-1:0] enable_stb_o
);

  logic [LVL_W-1:0]   level_q;
  logic               update_q;
  logic [CHAIN_N-1:0] sel_oh;
  irl_cmd_t           cmd [CHAIN_N];

  irl_level_reg #(.LVL_W(LVL_W)) u_lvl (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_i  (level_i),
    .level_q  (level_q),
    .update_q (update_q)
  );

  irl_pos_decode #(.LVL_W(LVL_W), .CHAIN_N(CHAIN_N)) u_dec (
    .level_q  (level_q),
    .update_q (update_q),
    .sel_oh   (sel_oh)
  );

  for (genvar gi = 0; gi < CHAIN_N; gi++) begin : g_cell
    irl_strobe_cell u_cell (
      .update_q (update_q),
      .sel      (sel_oh[gi]),
      .active   (src_active_i[gi]),
      .cnt_zero (src_cnt_zero_i[gi]),
      .cmd      (cmd[gi])
    );
    always_comb begin
      assert_stb_o[gi]   = cmd[gi].asrt;
      deassert_stb_o[gi] = cmd[gi].deasrt;
      enable_stb_o[gi]   = cmd[gi].enab;
    end
  end

endmodule

// File: rtl/irl_level_decoder_chk.sv
module irl_level_decoder_chk #(
  parameter int unsigned LVL_W   = 4,
  parameter int unsigned CHAIN_N = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LVL_W-1:0]   level_i,
  input logic [CHAIN_N-1:0] src_active_i,
  input logic [CHAIN_N-1:0] src_cnt_zero_i,
  input logic [CHAIN_N-1:0] assert_stb_o,
  input logic [CHAIN_N-1:0] deassert_stb_o,
  input logic [CHAIN_N-1:0] enable_stb_o
);

  // Edges seen since reset release, saturating at 2.
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= 2'd0;
    end else if (warm_q != 2'd2) begin
      warm_q <= warm_q + 2'd1;
    end
  end

  AST_ASSERT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(assert_stb_o)); // R9
  AST_ENABLE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(enable_stb_o)); // R9
  AST_NO_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
    (assert_stb_o & deassert_stb_o) == '0); // R6
  AST_ASSERT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (assert_stb_o & src_active_i) == '0); // R4
  AST_ENABLE_ONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_stb_o & ~src_cnt_zero_i) == '0); // R5
  AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2 && $past(level_i) == $past(level_i, 2))
      |-> (assert_stb_o | deassert_stb_o | enable_stb_o) == '0); // R2
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q != 2'd0 && $past(level_i) == '0)
      |-> (assert_stb_o | enable_stb_o) == '0); // R7

endmodule

bind irl_level_decoder irl_level_decoder_chk #(.LVL_W(LVL_W), .CHAIN_N(CHAIN_N)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .level_i        (level_i),
  .src_active_i   (src_active_i),
  .src_cnt_zero_i (src_cnt_zero_i),
  .assert_stb_o   (assert_stb_o),
  .deassert_stb_o (deassert_stb_o),
  .enable_stb_o   (enable_stb_o)
);

// File: tb/tb_irl_level_decoder.sv
module tb_irl_level_decoder;

  localparam int N = 15;

  logic         clk;
  logic         rst_n;
  logic [3:0]   level_i;
  logic [N-1:0] src_active_i;
  logic [N-1:0] src_cnt_zero_i;
  logic [N-1:0] assert_stb_o;
  logic [N-1:0] deassert_stb_o;
  logic [N-1:0] enable_stb_o;

  typedef struct {
    logic [N-1:0] a;
    logic [N-1:0] d;
    logic [N-1:0] e;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  int   m_prev  = 0;
  bit   done    = 0;

  irl_level_decoder dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .level_i        (level_i),
    .src_active_i   (src_active_i),
    .src_cnt_zero_i (src_cnt_zero_i),
    .assert_stb_o   (assert_stb_o),
    .deassert_stb_o (deassert_stb_o),
    .enable_stb_o   (enable_stb_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Driver: apply one cycle of stimulus and push the predicted strobes.
  task automatic drive(input int lvl, input logic [N-1:0] act,
                       input logic [N-1:0] cz, input string tag);
    exp_t x;
    int   pos;
    bit   chg;
    @(negedge clk);
    level_i        = 4'(lvl);
    src_active_i   = act;
    src_cnt_zero_i = cz;
    chg = (lvl != m_prev);
    pos = 15 - lvl;
    x.a = '0; x.d = '0; x.e = '0; x.tag = tag;
    for (int i = 0; i < N; i++) begin
      if (chg) begin
        if (i == pos) begin
          x.a[i] = !act[i];
          x.e[i] = cz[i];
        end else begin
          x.d[i] = act[i];
        end
      end
    end
    m_prev = lvl;
    q.push_back(x);
  endtask

  // Monitor: compare one cycle after the capturing edge.
  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      n_tests++;
      if (assert_stb_o !== x.a || deassert_stb_o !== x.d || enable_stb_o !== x.e) begin
        n_fail++;
        $display("FAIL %s: got a=%h d=%h e=%h exp a=%h d=%h e=%h", x.tag,
                 assert_stb_o, deassert_stb_o, enable_stb_o, x.a, x.d, x.e);
      end
    end
  end

  task automatic check_idle(input string tag);
    n_tests++;
    if ((assert_stb_o | deassert_stb_o | enable_stb_o) !== '0) begin
      n_fail++;
      $display("FAIL %s: got a=%h d=%h e=%h exp all 0", tag,
               assert_stb_o, deassert_stb_o, enable_stb_o);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    level_i = 4'd0;
    src_active_i = '1;
    src_cnt_zero_i = '1;
    m_prev = 0;
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_idle("R1 after release");
  endtask

  initial begin
    do_reset();
    drive(15, '0, '1, "R3 R4 R5 level 15 -> pos 0");
    drive(15, '0, '1, "R2 held level");
    drive(1, 15'h0001, '0, "R3 R6 level 1 -> pos 14");
    drive(8, 15'h0088, 15'h0080, "R4 R6 level 8 already active");
    drive(0, 15'h5555, '1, "R7 level 0 deasserts all");
    drive(0, 15'h5555, '1, "R2 level 0 held");
    drive(5, '0, '0, "R8 new level pulse");
    drive(5, '0, '0, "R8 pulse ends");
    drive(5, '1, '1, "R2 held with status change");
    for (int l = 1; l < 16; l++) begin
      drive(l, '1, '1, "R3 R9 sweep");
    end
    drive(12, '0, 15'h0008, "R5 R9 only selected enabled");
    repeat (3) @(negedge clk);
    // reset in mid-run, then resume
    do_reset();
    drive(0, '1, '1, "R1 R2 level 0 after reset quiet");
    drive(3, 15'h7000, '0, "R3 after reset");
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule